// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a legacy I/O controller on a byte-wide host I/O bus. It decodes two addresses. The first is an index port (0x2E) that selects a configuration register. The second is a data port (0x2F) that reads or writes the selected register. After reset the block is locked. The host must write a fixed four-byte key to the index port before any configuration register can be reached.

Once the block is unlocked, a logical-device-number register picks one of several banks. The per-device registers live in these banks: an activate bit and a 16-bit I/O base address. A read-only chip identity and revision are always visible. The host relocks the block with a two-step exit: it selects index 0x02, then writes 0x02 to the data port. The host bus is modelled as single-cycle read and write strobes with an address and a data byte. Each device's activate bit and base address are driven out to the rest of the chip.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is locked. The LDN register is 0, every activate bit is 0, every base address is 0, and `io_rdata` is 0xFF.
- R2: The block unlocks only after the bytes 0x87, 0x01, 0x55, 0x55 are written to address 0x2E in that order. `cfg_unlocked` goes high in the cycle after the write strobe of the last byte.
- R3: While the block is locked, a byte written to the index port that does not match the expected key byte returns the matcher to its start. The exception is a byte of 0x87, which counts as the first key byte. Writes to the data port do not move the matcher.
- R4: While the block is locked, reads of the data port return 0xFF. Writes to the data port change no register, and writes to the index port do not change the selected index.
- R5: While the block is unlocked, a data-port write of 0x02 with the index set to 0x02 locks the block again. A data-port write of any other value at index 0x02 leaves the block unlocked.
- R6: Index 0x20 reads the high byte of the chip ID and index 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero. Writes to these three indices have no effect.
- R7: Index 0x07 is an 8-bit LDN register that can be read and written. Its value selects the bank that the per-device indices reach.
- R8: Index 0x30 holds one activate bit per device in bit 0. A read returns bits 7:1 as zero. The bit of device n drives `dev_active[n]`.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) hold the 16-bit base address of the selected device. This value drives `dev_base[16n+15:16n]`.
- R10: When the LDN is NUM_DEV or larger, the per-device indices read 0x00 and writes to them change nothing. Any index not listed in R5–R9 reads 0x00.
- R11: `io_rdata` is loaded on the clock edge that samples `io_rd`. An index-port read returns the current index while the block is unlocked and 0xFF while it is locked. A read of any other address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read byte |
| cfg_unlocked | output | 1 | High while configuration mode is open |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device 0 in the low bits |

## Verification
A wrong matcher step shows up in `cfg_unlocked` on the strobe that follows. The block either opens on a corrupted key or stays shut after a correct one, so every key variant is followed at once by a check of that flag. A wrong LDN or a corrupted bank register surfaces on `dev_active` and `dev_base` in the cycle after the write, and on `io_rdata` one cycle after a data-port read. The sweeps therefore read every index back and compare the device outputs after every bank write. An accidental write while locked is invisible until the block is unlocked, so the bench reopens the block and reads the LDN and device state back.

// File: rtl/cfgport_pkg.sv
// Package: constants shared by the configuration port controller.
// Assumes byte-wide host data and 8-bit register indices.
package cfgport_pkg;

    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;
    localparam logic [7:0] KEY_B3 = 8'h55;

    localparam logic [7:0] IDX_EXIT   = 8'h02;
    localparam logic [7:0] VAL_EXIT   = 8'h02;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] IDX_REV    = 8'h22;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] IDX_BASE_H = 8'h60;
    localparam logic [7:0] IDX_BASE_L = 8'h61;

    // Key byte expected at a given matcher step.
    function automatic logic [7:0] key_byte(input logic [1:0] step);
        case (step)
            2'd0:    key_byte = KEY_B0;
            2'd1:    key_byte = KEY_B1;
            2'd2:    key_byte = KEY_B2;
            default: key_byte = KEY_B3;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_unlock.sv
// Unlock matcher: watches index-port writes for the four-byte key and
// opens configuration mode; closes it again on the exit write.
// Assumes idx_wr/data_wr are single-cycle strobes already address-decoded.
module cfgport_unlock
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] index_q,
    output logic       unlocked
);

    logic [1:0] step_q;

    // Advance, restart or clear the key matcher; handle the exit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= 2'd0;
            unlocked <= 1'b0;
        end else if (!unlocked) begin
            if (idx_wr) begin
                if (wdata == key_byte(step_q)) begin
                    if (step_q == 2'd3) begin
                        unlocked <= 1'b1;
                        step_q   <= 2'd0;
                    end else begin
                        step_q <= step_q + 2'd1;
                    end
                end else if (wdata == KEY_B0) begin
                    step_q <= 2'd1;
                end else begin
                    step_q <= 2'd0;
                end
            end
        end else if (data_wr && index_q == IDX_EXIT && wdata == VAL_EXIT) begin
            unlocked <= 1'b0;
        end
    end

    // R2: opening only ever follows an index write of the last key byte.
    assert_open_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_B3));

    // R5: the exit write closes configuration mode on the next edge.
    assert_exit_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && data_wr && index_q == IDX_EXIT && wdata == VAL_EXIT) |=> !unlocked);

    // R3: data-port traffic never opens the block.
    assert_data_no_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !idx_wr) |=> !unlocked);

endmodule

// File: rtl/cfgport_bank.sv
// Bank register file: LDN register plus per-device activate and base
// registers, one set per logical device, selected by the LDN.
// Assumes wr_en is already qualified by configuration mode.
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              idx,
    input  logic [7:0]              wdata,
    output logic [7:0]              ldn_q,
    output logic [7:0]              rd_byte,
    output logic [NUM_DEV-1:0]      dev_active,
    output logic [16*NUM_DEV-1:0]   dev_base
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [15:0]      base_q [NUM_DEV];
    logic             ldn_ok;
    logic [SEL_W-1:0] sel;

    assign ldn_ok = ({24'd0, ldn_q} < NUM_DEV);
    assign sel    = ldn_q[SEL_W-1:0];

    // LDN register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= 8'h00;
        else if (wr_en && idx == IDX_LDN)
            ldn_q <= wdata;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        // Per-device activate and base register writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dev_active[d] <= 1'b0;
                base_q[d]     <= 16'h0000;
            end else if (wr_en && ldn_q == 8'(d)) begin
                case (idx)
                    IDX_ACT:    dev_active[d]   <= wdata[0];
                    IDX_BASE_H: base_q[d][15:8] <= wdata;
                    IDX_BASE_L: base_q[d][7:0]  <= wdata;
                    default: ;
                endcase
            end
        end
        assign dev_base[16*d +: 16] = base_q[d];
    end

    // Read byte for the bank-owned indices; zero elsewhere.
    always_comb begin
        rd_byte = 8'h00;
        case (idx)
            IDX_LDN:    rd_byte = ldn_q;
            IDX_ACT:    if (ldn_ok) rd_byte = {7'd0, dev_active[sel]};
            IDX_BASE_H: if (ldn_ok) rd_byte = base_q[sel][15:8];
            IDX_BASE_L: if (ldn_ok) rd_byte = base_q[sel][7:0];
            default:    rd_byte = 8'h00;
        endcase
    end

    // R10: writes with an out-of-range LDN leave every device unchanged.
    assert_bad_ldn_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldn_ok) |=> ($stable(dev_active) && $stable(dev_base)));

    // R8: no write strobe, no activate change.
    assert_act_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dev_active));

endmodule

// File: rtl/cfgport_ctrl.sv
// Top: decodes the index and data ports, holds the index register, and
// muxes read data from the identity constants and the bank file.
// Assumes one strobe per access and a single-cycle host bus.
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int          NUM_DEV    = 4,
    parameter logic [15:0] INDEX_PORT = 16'h002E,
    parameter logic [15:0] DATA_PORT  = 16'h002F,
    parameter logic [15:0] CHIP_ID    = 16'h5A3C,
    parameter logic [3:0]  CHIP_REV   = 4'h6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           io_addr,
    input  logic [7:0]            io_wdata,
    input  logic                  io_wr,
    input  logic                  io_rd,
    output logic [7:0]            io_rdata,
    output logic                  cfg_unlocked,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [16*NUM_DEV-1:0] dev_base
);

    logic       idx_hit, data_hit, idx_wr, data_wr;
    logic [7:0] index_q, bank_byte, ldn_q, cfg_byte;

    assign idx_hit  = (io_addr == INDEX_PORT);
    assign data_hit = (io_addr == DATA_PORT);
    assign idx_wr   = io_wr && idx_hit;
    assign data_wr  = io_wr && data_hit;

    cfgport_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .data_wr  (data_wr),
        .wdata    (io_wdata),
        .index_q  (index_q),
        .unlocked (cfg_unlocked)
    );

    cfgport_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (data_wr && cfg_unlocked),
        .idx        (index_q),
        .wdata      (io_wdata),
        .ldn_q      (ldn_q),
        .rd_byte    (bank_byte),
        .dev_active (dev_active),
        .dev_base   (dev_base)
    );

    // Index register: loaded only in configuration mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (idx_wr && cfg_unlocked)
            index_q <= io_wdata;
    end

    // Configuration read byte for the selected index.
    always_comb begin
        case (index_q)
            IDX_ID_HI: cfg_byte = CHIP_ID[15:8];
            IDX_ID_LO: cfg_byte = CHIP_ID[7:0];
            IDX_REV:   cfg_byte = {4'h0, CHIP_REV};
            default:   cfg_byte = bank_byte;
        endcase
    end

    // Registered read data for the strobed address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            io_rdata <= 8'hFF;
        else if (io_rd) begin
            if (idx_hit && cfg_unlocked)
                io_rdata <= index_q;
            else if (data_hit && cfg_unlocked)
                io_rdata <= cfg_byte;
            else
                io_rdata <= 8'hFF;
        end
    end

    // R4: locked data-port reads return the idle pattern.
    assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && data_hit && !cfg_unlocked) |=> io_rdata == 8'hFF);

    // R4: locked data-port writes do not reach the LDN register.
    assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cfg_unlocked) |=> $stable(ldn_q));

    // R6: the chip ID high byte is returned on the next edge.
    assert_id_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && data_hit && cfg_unlocked && index_q == IDX_ID_HI) |=> io_rdata == CHIP_ID[15:8]);

endmodule

// File: tb/tb_cfgport_ctrl.sv
// Bench for cfgport_ctrl: directed key checks plus sweeps over every
// index, every LDN up to twice the device count and every wrong key byte.
module tb_cfgport_ctrl;

    localparam int          NUM_DEV = 4;
    localparam logic [15:0] IDXP    = 16'h002E;
    localparam logic [15:0] DATP    = 16'h002F;
    localparam logic [15:0] CID     = 16'h5A3C;
    localparam logic [3:0]  CREV    = 4'h6;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [15:0]           io_addr = 16'h0;
    logic [7:0]            io_wdata = 8'h0;
    logic                  io_wr = 1'b0;
    logic                  io_rd = 1'b0;
    logic [7:0]            io_rdata;
    logic                  cfg_unlocked;
    logic [NUM_DEV-1:0]    dev_active;
    logic [16*NUM_DEV-1:0] dev_base;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic        m_act  [NUM_DEV];
    logic [15:0] m_base [NUM_DEV];
    logic [7:0]  m_ldn;

    always #10 clk = ~clk;

    cfgport_ctrl #(.NUM_DEV(NUM_DEV), .CHIP_ID(CID), .CHIP_REV(CREV)) dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .cfg_unlocked(cfg_unlocked), .dev_active(dev_active), .dev_base(dev_base)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic unlock();
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] idx);
        logic ok;
        ok = (int'(m_ldn) < NUM_DEV);
        case (idx)
            8'h07: exp_byte = m_ldn;
            8'h20: exp_byte = CID[15:8];
            8'h21: exp_byte = CID[7:0];
            8'h22: exp_byte = {4'h0, CREV};
            8'h30: exp_byte = ok ? {7'd0, m_act[m_ldn[1:0]]} : 8'h00;
            8'h60: exp_byte = ok ? m_base[m_ldn[1:0]][15:8] : 8'h00;
            8'h61: exp_byte = ok ? m_base[m_ldn[1:0]][7:0] : 8'h00;
            default: exp_byte = 8'h00;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        for (int d = 0; d < NUM_DEV; d++) begin
            check(req, dev_active[d], m_act[d]);
            check(req, dev_base[16*d +: 16], m_base[d]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int d = 0; d < NUM_DEV; d++) begin m_act[d] = 1'b0; m_base[d] = 16'h0; end
        m_ldn = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 locked", cfg_unlocked, 1'b0);
        check("R1 rdata", io_rdata, 8'hFF);
        check_outputs("R1 outputs");
        rd(DATP, r);  check("R1/R4 locked data read", r, 8'hFF);
        rd(IDXP, r);  check("R11 locked index read", r, 8'hFF);

        // R4 locked data writes ignored (observed after unlock)
        wr(DATP, 8'h03);
        // R2 partial key stays locked, full key opens
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55);
        check("R2 three bytes", cfg_unlocked, 1'b0);
        wr(DATP, 8'h11);
        check("R3 data write no effect on matcher", cfg_unlocked, 1'b0);
        wr(IDXP, 8'h55);
        check("R2 unlocked", cfg_unlocked, 1'b1);
        wr(IDXP, 8'h07);
        rd(DATP, r); check("R4 LDN untouched by locked write", r, 8'h00);

        // R11 index readback, other address reads FF
        wr(IDXP, 8'h22);
        rd(IDXP, r); check("R11 index read", r, 8'h22);
        rd(16'h0080, r); check("R11 foreign address", r, 8'hFF);

        // R6 identity, writes ignored
        for (int i = 0; i < 3; i++) begin
            wr(IDXP, 8'h20 + 8'(i));
            wr(DATP, 8'h00);
            rd(DATP, r); check("R6 identity", r, exp_byte(8'h20 + 8'(i)));
        end

        // R10 sweep every index at LDN 0 with reset bank
        for (int i = 0; i < 256; i++) begin
            if (i == 2) continue;
            wr(IDXP, 8'(i));
            rd(DATP, r); check("R10 index sweep", r, exp_byte(8'(i)));
        end

        // R7 R8 R9 R10 device sweep over in-range and out-of-range LDN
        for (int d = 0; d < 2*NUM_DEV; d++) begin
            wr(IDXP, 8'h07); wr(DATP, 8'(d)); m_ldn = 8'(d);
            rd(DATP, r); check("R7 LDN readback", r, 8'(d));
            wr(IDXP, 8'h30); wr(DATP, 8'hFE | 8'(d & 1));
            wr(IDXP, 8'h60); wr(DATP, 8'h10 + 8'(d));
            wr(IDXP, 8'h61); wr(DATP, 8'hA0 + 8'(3*d));
            if (d < NUM_DEV) begin
                m_act[d]  = 1'(d & 1);
                m_base[d] = {8'h10 + 8'(d), 8'hA0 + 8'(3*d)};
            end
            check_outputs("R8/R9/R10 device outputs");
        end
        for (int d = 0; d < 2*NUM_DEV; d++) begin
            wr(IDXP, 8'h07); wr(DATP, 8'(d)); m_ldn = 8'(d);
            wr(IDXP, 8'h30); rd(DATP, r); check("R8 activate read", r, exp_byte(8'h30));
            wr(IDXP, 8'h60); rd(DATP, r); check("R9 base high", r, exp_byte(8'h60));
            wr(IDXP, 8'h61); rd(DATP, r); check("R9 base low", r, exp_byte(8'h61));
        end

        // R5 exit
        wr(IDXP, 8'h02); wr(DATP, 8'h05);
        check("R5 wrong exit value", cfg_unlocked, 1'b1);
        wr(DATP, 8'h02);
        check("R5 relocked", cfg_unlocked, 1'b0);
        rd(DATP, r); check("R5/R4 locked read", r, 8'hFF);

        // R3 wrong third byte never opens
        for (int b = 0; b < 256; b++) begin
            if (b == 8'h55) continue;
            wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'(b));
            wr(IDXP, 8'h55); wr(IDXP, 8'h55);
            check("R3 bad key byte", cfg_unlocked, 1'b0);
        end

        // R4 locked writes then R3 restart on repeated 0x87
        wr(DATP, 8'h00); wr(DATP, 8'h02);
        check_outputs("R4 locked writes keep devices");
        wr(IDXP, 8'h87); wr(IDXP, 8'h87); wr(IDXP, 8'h01);
        wr(IDXP, 8'h55); wr(IDXP, 8'h55);
        check("R3 restart on 0x87", cfg_unlocked, 1'b1);
        rd(IDXP, r); check("R4 index kept while locked", r, 8'h02);
        wr(IDXP, 8'h07);
        rd(DATP, r); check("R4 LDN kept while locked", r, m_ldn);
        check_outputs("R4 devices after reopen");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule